// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block sits between a CPU register bus and an on-chip nonvolatile array that is 16 bits wide. Software first loads an address and a data word. It then writes a one-byte command code, and the controller carries out that command. The controller can read one halfword, program one halfword, erase one 512-byte page (256 halfwords), or fold a whole page into a 24-bit checksum. While a command runs, the bus stall output holds the CPU. The stall falls in the cycle after the command finishes.

Programming can only clear bits. The new word is ANDed into the stored word, and each halfword may be programmed at most twice before its page is erased again. The time a program takes depends on the clock-divider code on `clk_div`. The erase time is fixed. All durations are cycle counts set by parameters, so a bench can use short values. The array is a register-file model that comes up erased after reset.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, `bus_stall` is 0 and the status, mode, data, address and signature registers all read 0. Every array halfword reads 0xFFFF.
- R2: The bus offsets are 0 status (read-only), 1 mode (8 bits), 2 command (reads 0), 3 data (16 bits), 4 address (16 bits) and 5 signature (24 bits, read-only). Offsets 6 and 7 read 0, and writes to read-only offsets change nothing.
- R3: The status bits are [0] busy, [1] last command succeeded, [2] unknown command code, [3] program rejected after two writes, [4] program or erase refused because mode bit 0 is clear. Starting any valid non-idle command clears bits 1 to 4.
- R4: Code 0x01 stalls for 1 cycle and then loads the data register with the halfword selected by address bits [9:1]. Address bit 0 is ignored.
- R5: Code 0x02, with mode bit 0 set, stalls for T_WR_A cycles when clk_div is 0 to 3, T_WR_B cycles when it is 4 or 5, T_WR_C cycles when it is 6 and T_WR_D cycles when it is 7. It then stores (old AND data) and sets status bit 1.
- R6: A code 0x02 aimed at a halfword that has already been programmed twice since its last erase still stalls for the full program time. It leaves the array unchanged and sets status bit 3.
- R7: Code 0x05, with mode bit 0 set, stalls for T_ERASE cycles whatever clk_div is. It sets every halfword of the page selected by address bit 9 to 0xFFFF and resets the write count of each of those halfwords. The other page is untouched.
- R8: When mode bit 0 is clear, codes 0x02 and 0x05 stall for 1 cycle, set status bit 4 and leave the array unchanged.
- R9: Code 0x06 stalls for 256 cycles. It then holds in the signature register the value s, which starts at 0 and, for each halfword of the addressed page from offset 0 to offset 255, is updated as s = rotate-left-by-1(s) XOR halfword (24-bit).
- R10: Any code other than 0x00, 0x01, 0x02, 0x05 and 0x06 sets status bit 2 and clears bits 1, 3 and 4, with no stall and no array change. Code 0x00 changes nothing.
- R11: While `bus_stall` is 1, every bus write is ignored, including a command write made in the final stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_div | input | 3 | Clock-divider code that selects the program duration |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 24 | Read data for the selected offset |
| bus_stall | output | 1 | Holds the CPU while a command runs |

## Verification
Two things can fall in the same clock edge: the completion of a running command (array update and stall release) and a new bus write. The bench starts an erase and, while it is stalled, writes the data and address registers. In the very last stall cycle it presents a read command. The result is judged from the measured stall length, which must equal exactly the erase time, and from the status and data registers read afterwards. These must show no trace of the late command and no change to the values written during the stall.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int OFF_W   = 8;
  localparam int PAGE_HW = 1 << OFF_W;
  localparam int SIG_W   = 24;

  localparam logic [2:0] RA_STAT = 3'd0;
  localparam logic [2:0] RA_MODE = 3'd1;
  localparam logic [2:0] RA_CMD  = 3'd2;
  localparam logic [2:0] RA_DATA = 3'd3;
  localparam logic [2:0] RA_ADDR = 3'd4;
  localparam logic [2:0] RA_SIG  = 3'd5;

  localparam logic [7:0] CODE_IDLE = 8'h00;
  localparam logic [7:0] CODE_RD   = 8'h01;
  localparam logic [7:0] CODE_WR   = 8'h02;
  localparam logic [7:0] CODE_ER   = 8'h05;
  localparam logic [7:0] CODE_SIG  = 8'h06;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_ER   = 3'd3,
    OP_SIG  = 3'd4
  } op_e;

  function automatic logic code_known(input logic [7:0] c);
    return c inside {CODE_IDLE, CODE_RD, CODE_WR, CODE_ER, CODE_SIG};
  endfunction

  function automatic op_e code_op(input logic [7:0] c);
    case (c)
      CODE_RD:  return OP_RD;
      CODE_WR:  return OP_WR;
      CODE_ER:  return OP_ER;
      CODE_SIG: return OP_SIG;
      default:  return OP_NONE;
    endcase
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fcmd_timer.sv
module fcmd_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] dur,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en = load | run_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (load) begin
      run_d = 1'b1;
      cnt_d = dur - CNT_W'(1);
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = run_q && (cnt_q == '0);

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array #(
  parameter int IDX_W = 9,
  parameter int OFF_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [15:0]            rd_data,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [15:0]            wr_data,
  output logic [1:0]             wcnt,
  input  logic                   er_en,
  input  logic [IDX_W-OFF_W-1:0] er_page
);

  localparam int WORDS = 1 << IDX_W;
  localparam int PG_W  = IDX_W - OFF_W;

  logic [15:0] word_v [WORDS];
  logic [1:0]  cnt_v  [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [15:0] m_q, m_d;
    logic [1:0]  c_q, c_d;
    logic        hit_e, hit_w;

    assign hit_e = er_en && (er_page == PG_W'(g >> OFF_W));
    assign hit_w = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      m_d = m_q;
      c_d = c_q;
      if (hit_e) begin
        m_d = '1;
        c_d = 2'd0;
      end else if (hit_w) begin
        m_d = m_q & wr_data;
        c_d = c_q + 2'd1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= '1;
        c_q <= 2'd0;
      end else if (hit_e || hit_w) begin
        m_q <= m_d;
        c_q <= c_d;
      end
    end

    assign word_v[g] = m_q;
    assign cnt_v[g]  = c_q;
  end

  assign rd_data = word_v[rd_idx];
  assign wcnt    = cnt_v[wr_idx];

endmodule

// File: rtl/fcmd_sig.sv
module fcmd_sig #(
  parameter int SIG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             fin,
  input  logic [15:0]      word,
  output logic [SIG_W-1:0] sig
);

  logic [SIG_W-1:0] acc_q, acc_d, sig_q, sig_d, fold;

  assign fold = {acc_q[SIG_W-2:0], acc_q[SIG_W-1]} ^ SIG_W'(word);

  always_comb begin
    acc_d = acc_q;
    if (clr)       acc_d = '0;
    else if (step) acc_d = fold;
    sig_d = fin ? fold : sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sig_q <= '0;
    end else begin
      if (clr || step) acc_q <= acc_d;
      if (fin)         sig_q <= sig_d;
    end
  end

  assign sig = sig_q;

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int PAGES   = 2,
  parameter int T_ERASE = 40,
  parameter int T_WR_A  = 8,
  parameter int T_WR_B  = 11,
  parameter int T_WR_C  = 13,
  parameter int T_WR_D  = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  clk_div,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [23:0] bus_rdata,
  output logic        bus_stall
);

  localparam int HW_TOTAL = PAGES * PAGE_HW;
  localparam int IDX_W    = $clog2(HW_TOTAL);
  localparam int PG_W     = IDX_W - OFF_W;
  localparam int MAXD     = imax(imax(imax(T_ERASE, PAGE_HW), imax(T_WR_A, T_WR_B)),
                                 imax(T_WR_C, T_WR_D));
  localparam int CNT_W    = $clog2(MAXD + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  // architectural state
  logic [7:0]  mode_q, mode_d;
  logic [15:0] data_q, data_d;
  logic [15:0] addr_q, addr_d;
  logic        busy_q, busy_d;
  op_e         op_q, op_d;
  logic        lock_q, lock_d;
  logic        ok_q, ok_d, bad_q, bad_d, ovr_q, ovr_d, lck_q, lck_d;

  // bus decode
  logic       reg_wr, cmd_wr, start, code_bad, lock_new;
  logic [7:0] code;
  op_e        op_new;

  assign reg_wr   = bus_sel && bus_wr && !busy_q;
  assign cmd_wr   = reg_wr && (bus_addr == RA_CMD);
  assign code     = bus_wdata[7:0];
  assign op_new   = code_op(code);
  assign start    = cmd_wr && (op_new != OP_NONE);
  assign code_bad = cmd_wr && !code_known(code);
  assign lock_new = !mode_q[0] && ((op_new == OP_WR) || (op_new == OP_ER));

  // duration of the command being started
  logic [CNT_W-1:0] dur_new, tm_cnt;
  logic             fin;

  always_comb begin
    dur_new = CNT_W'(1);
    case (op_new)
      OP_WR: begin
        if (!lock_new) begin
          if (clk_div < 3'd4)       dur_new = CNT_W'(T_WR_A);
          else if (clk_div < 3'd6)  dur_new = CNT_W'(T_WR_B);
          else if (clk_div == 3'd6) dur_new = CNT_W'(T_WR_C);
          else                      dur_new = CNT_W'(T_WR_D);
        end
      end
      OP_ER:   if (!lock_new) dur_new = CNT_W'(T_ERASE);
      OP_SIG:  dur_new = CNT_W'(PAGE_HW);
      default: dur_new = CNT_W'(1);
    endcase
  end

  fcmd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_l),
    .load  (start),
    .dur   (dur_new),
    .cnt   (tm_cnt),
    .last  (fin)
  );

  // array access
  logic             sig_run;
  logic [IDX_W-1:0] rd_idx, hw_idx;
  logic [PG_W-1:0]  pg_sel;
  logic [15:0]      rd_data;
  logic [1:0]       wcnt;
  logic             wr_go, er_go;
  logic [SIG_W-1:0] sig_val;

  assign sig_run = busy_q && (op_q == OP_SIG);
  assign hw_idx  = addr_q[IDX_W:1];
  assign pg_sel  = addr_q[IDX_W:OFF_W+1];
  assign rd_idx  = sig_run ? {pg_sel, ~tm_cnt[OFF_W-1:0]} : hw_idx;
  assign wr_go   = fin && (op_q == OP_WR) && !lock_q && (wcnt != 2'd2);
  assign er_go   = fin && (op_q == OP_ER) && !lock_q;

  fcmd_array #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_l),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (wr_go),
    .wr_idx  (hw_idx),
    .wr_data (data_q),
    .wcnt    (wcnt),
    .er_en   (er_go),
    .er_page (pg_sel)
  );

  fcmd_sig #(.SIG_W(SIG_W)) u_sig (
    .clk   (clk),
    .rst_n (rst_l),
    .clr   (start && (op_new == OP_SIG)),
    .step  (sig_run),
    .fin   (fin && (op_q == OP_SIG)),
    .word  (rd_data),
    .sig   (sig_val)
  );

  // next state
  logic reg_en;
  assign reg_en = reg_wr | fin;

  always_comb begin
    mode_d = mode_q;
    data_d = data_q;
    addr_d = addr_q;
    busy_d = busy_q;
    op_d   = op_q;
    lock_d = lock_q;
    ok_d   = ok_q;
    bad_d  = bad_q;
    ovr_d  = ovr_q;
    lck_d  = lck_q;
    if (reg_wr) begin
      case (bus_addr)
        RA_MODE: mode_d = bus_wdata[7:0];
        RA_DATA: data_d = bus_wdata;
        RA_ADDR: addr_d = bus_wdata;
        default: ;
      endcase
    end
    if (start) begin
      busy_d = 1'b1;
      op_d   = op_new;
      lock_d = lock_new;
      ok_d   = 1'b0;
      bad_d  = 1'b0;
      ovr_d  = 1'b0;
      lck_d  = 1'b0;
    end
    if (code_bad) begin
      bad_d = 1'b1;
      ok_d  = 1'b0;
      ovr_d = 1'b0;
      lck_d = 1'b0;
    end
    if (fin) begin
      busy_d = 1'b0;
      if (lock_q)                                  lck_d = 1'b1;
      else if ((op_q == OP_WR) && (wcnt == 2'd2))  ovr_d = 1'b1;
      else                                         ok_d  = 1'b1;
      if (op_q == OP_RD) data_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      mode_q <= '0;
      data_q <= '0;
      addr_q <= '0;
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      lock_q <= 1'b0;
      ok_q   <= 1'b0;
      bad_q  <= 1'b0;
      ovr_q  <= 1'b0;
      lck_q  <= 1'b0;
    end else if (reg_en) begin
      mode_q <= mode_d;
      data_q <= data_d;
      addr_q <= addr_d;
      busy_q <= busy_d;
      op_q   <= op_d;
      lock_q <= lock_d;
      ok_q   <= ok_d;
      bad_q  <= bad_d;
      ovr_q  <= ovr_d;
      lck_q  <= lck_d;
    end
  end

  // read mux
  always_comb begin
    case (bus_addr)
      RA_STAT: bus_rdata = {19'd0, lck_q, ovr_q, bad_q, ok_q, busy_q};
      RA_MODE: bus_rdata = {16'd0, mode_q};
      RA_DATA: bus_rdata = {8'd0, data_q};
      RA_ADDR: bus_rdata = {8'd0, addr_q};
      RA_SIG:  bus_rdata = sig_val;
      default: bus_rdata = '0;
    endcase
  end

  assign bus_stall = busy_q;

  logic unused_bits;
  assign unused_bits = ^{addr_q[0], addr_q[15:IDX_W+1], tm_cnt, bus_sel & ~bus_wr};

endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk
  import fcmd_pkg::*;
(
  input logic        clk,
  input logic        rst_l,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic        bus_stall,
  input logic        busy_q,
  input op_e         op_q,
  input logic [15:0] data_q,
  input logic [15:0] addr_q,
  input logic [1:0]  wcnt,
  input logic        bad_q
);

  logic cmd_acc;
  assign cmd_acc = bus_sel && bus_wr && !bus_stall && (bus_addr == RA_CMD);

  assert_stall_start_R5: assert property (@(posedge clk) disable iff (!rst_l)
    (cmd_acc && code_known(bus_wdata[7:0]) && (bus_wdata[7:0] != CODE_IDLE)) |=> bus_stall);

  assert_bad_code_R10: assert property (@(posedge clk) disable iff (!rst_l)
    (cmd_acc && !code_known(bus_wdata[7:0])) |=> (!bus_stall && bad_q));

  assert_hold_regs_R11: assert property (@(posedge clk) disable iff (!rst_l)
    (busy_q && (op_q != OP_RD)) |=> ($stable(data_q) && $stable(addr_q)));

  assert_wcount_cap_R6: assert property (@(posedge clk) disable iff (!rst_l)
    wcnt != 2'd3);

endmodule

bind fcmd_ctrl fcmd_chk u_chk (
  .clk       (clk),
  .rst_l     (rst_l),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_stall (bus_stall),
  .busy_q    (busy_q),
  .op_q      (op_q),
  .data_q    (data_q),
  .addr_q    (addr_q),
  .wcnt      (wcnt),
  .bad_q     (bad_q)
);

// File: tb/sim_fcmd_ctrl.sv
module sim_fcmd_ctrl;
  import fcmd_pkg::*;

  localparam int TE = 40, TA = 8, TB = 11, TC = 13, TD = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_div = 3'd0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [23:0] bus_rdata;
  logic        bus_stall;

  always #10ns clk = ~clk;

  fcmd_ctrl #(.PAGES(2), .T_ERASE(TE), .T_WR_A(TA), .T_WR_B(TB), .T_WR_C(TC), .T_WR_D(TD)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall)
  );

  int checks = 0, errors = 0;
  logic [15:0] em [512];
  logic [1:0]  ec [512];
  logic [15:0] m_addr = 16'd0, m_data = 16'd0;
  logic [7:0]  m_mode = 8'd0;

  logic [23:0] exp_q [$];
  string       tag_q [$];
  event        mon_go;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the read data
  always @(mon_go) begin : mon
    logic [23:0] e;
    string       t;
    if (exp_q.size() == 0) begin
      chk("monitor-queue-empty", 24'd1, 24'd0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, bus_rdata, e);
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [23:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #5ns;
    -> mon_go;
    #1ns;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] code, input int exp_stall, input string tag);
    int n = 0;
    wr_reg(RA_CMD, {8'd0, code});
    while (bus_stall) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " stall"}, 24'(n), 24'(exp_stall));
  endtask

  function automatic int twr(input logic [2:0] cd);
    if (cd < 3'd4) return TA;
    if (cd < 3'd6) return TB;
    if (cd == 3'd6) return TC;
    return TD;
  endfunction

  function automatic int hidx(input logic [15:0] a);
    return int'(a[9:1]);
  endfunction

  task automatic set_addr(input logic [15:0] a); wr_reg(RA_ADDR, a); m_addr = a; endtask
  task automatic set_data(input logic [15:0] d); wr_reg(RA_DATA, d); m_data = d; endtask
  task automatic set_mode(input logic [7:0] m);  wr_reg(RA_MODE, {8'd0, m}); m_mode = m; endtask

  task automatic do_read(input string tag);
    cmd(CODE_RD, 1, tag);
    m_data = em[hidx(m_addr)];
    rd_reg(RA_DATA, {8'd0, m_data}, {tag, " data"});
  endtask

  task automatic do_write(input string tag);
    int i = hidx(m_addr);
    int es;
    logic [23:0] st;
    if (!m_mode[0]) begin
      es = 1; st = 24'h10;
    end else if (ec[i] == 2'd2) begin
      es = twr(clk_div); st = 24'h08;
    end else begin
      es = twr(clk_div); st = 24'h02;
      em[i] = em[i] & m_data;
      ec[i] = ec[i] + 2'd1;
    end
    cmd(CODE_WR, es, tag);
    rd_reg(RA_STAT, st, {tag, " status"});
  endtask

  task automatic do_erase(input string tag);
    int es = m_mode[0] ? TE : 1;
    if (m_mode[0]) begin
      for (int k = 0; k < 256; k++) begin
        em[int'(m_addr[9]) * 256 + k] = 16'hFFFF;
        ec[int'(m_addr[9]) * 256 + k] = 2'd0;
      end
    end
    cmd(CODE_ER, es, tag);
    rd_reg(RA_STAT, m_mode[0] ? 24'h02 : 24'h10, {tag, " status"});
  endtask

  task automatic do_sig(input string tag);
    logic [23:0] s = 24'd0;
    for (int k = 0; k < 256; k++)
      s = {s[22:0], s[23]} ^ {8'd0, em[int'(m_addr[9]) * 256 + k]};
    cmd(CODE_SIG, 256, tag);
    rd_reg(RA_SIG, s, {tag, " value"});
    rd_reg(RA_STAT, 24'h02, {tag, " status"});
  endtask

  // erase with bus writes during the stall and a command in its last cycle
  task automatic erase_collide(input string tag);
    int n = 0;
    for (int k = 0; k < 256; k++) begin
      em[int'(m_addr[9]) * 256 + k] = 16'hFFFF;
      ec[int'(m_addr[9]) * 256 + k] = 2'd0;
    end
    wr_reg(RA_CMD, {8'd0, CODE_ER});
    while (bus_stall) begin
      n++;
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (n == 2) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = RA_DATA; bus_wdata = 16'hDEAD;
      end else if (n == 3) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = RA_ADDR; bus_wdata = 16'h0202;
      end else if (n == TE) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = RA_CMD; bus_wdata = {8'd0, CODE_RD};
      end
      @(negedge clk);
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk({tag, " stall"}, 24'(n), 24'(TE));
    rd_reg(RA_STAT, 24'h02, {tag, " status"});
    rd_reg(RA_DATA, {8'd0, m_data}, {tag, " data kept"});
    rd_reg(RA_ADDR, {8'd0, m_addr}, {tag, " addr kept"});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 24'd1, 24'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 512; k++) begin em[k] = 16'hFFFF; ec[k] = 2'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 stall after reset", 24'(bus_stall), 24'd0);
    rd_reg(RA_STAT, 24'h0, "R1 status");
    rd_reg(RA_MODE, 24'h0, "R1 mode");
    rd_reg(RA_DATA, 24'h0, "R1 data");
    rd_reg(RA_ADDR, 24'h0, "R1 addr");
    rd_reg(RA_SIG,  24'h0, "R1 sig");
    set_addr(16'h0010);
    do_read("R1 R4 erased read");

    // R2 register map
    set_mode(8'hA5);
    rd_reg(RA_MODE, 24'h0000A5, "R2 mode");
    set_data(16'h1234);
    rd_reg(RA_DATA, 24'h001234, "R2 data");
    set_addr(16'h0103);
    rd_reg(RA_ADDR, 24'h000103, "R2 addr");
    wr_reg(RA_STAT, 16'hFFFF);
    rd_reg(RA_STAT, 24'h02, "R2 R3 status read-only");
    wr_reg(RA_SIG, 16'hFFFF);
    rd_reg(RA_SIG, 24'h0, "R2 sig read-only");
    rd_reg(RA_CMD, 24'h0, "R2 cmd reads zero");
    rd_reg(3'd6, 24'h0, "R2 offset 6");
    rd_reg(3'd7, 24'h0, "R2 offset 7");

    // R8 locked program and erase
    set_mode(8'h00);
    set_addr(16'h0020);
    set_data(16'h0F0F);
    do_write("R8 locked write");
    do_read("R8 array unchanged");
    do_erase("R8 locked erase");

    // R5 program timing per divider group and AND behaviour
    set_mode(8'h01);
    clk_div = 3'd0;
    set_data(16'hF0F0);
    do_write("R5 write cd0");
    do_read("R5 readback cd0");
    clk_div = 3'd5;
    set_data(16'h3C3C);
    do_write("R5 write cd5 and");
    do_read("R5 readback and");

    // R6 third write rejected
    clk_div = 3'd6;
    set_data(16'h0000);
    do_write("R6 third write");
    do_read("R6 array unchanged");

    // R5 cd7 in second page, R4 address bit 0 ignored
    clk_div = 3'd7;
    set_addr(16'h0202);
    set_data(16'h1357);
    do_write("R5 write cd7");
    set_addr(16'h0203);
    do_read("R4 bit0 ignored");
    clk_div = 3'd3;
    set_addr(16'h0204);
    set_data(16'h8001);
    do_write("R5 write cd3");

    // R9 signatures of both pages
    set_addr(16'h0020);
    do_sig("R9 sig page0");
    set_addr(16'h0300);
    do_sig("R9 sig page1");

    // R10 unknown and idle codes
    set_addr(16'h0020);
    cmd(8'h07, 0, "R10 bad code");
    rd_reg(RA_STAT, 24'h04, "R10 bad status");
    cmd(CODE_IDLE, 0, "R10 idle");
    rd_reg(RA_STAT, 24'h04, "R10 idle no effect");
    cmd(8'hFF, 0, "R10 code ff");
    do_read("R10 array unchanged");

    // R11 and R7 erase with colliding accesses; page1 untouched
    clk_div = 3'd7;
    set_data(16'h5A5A);
    set_addr(16'h0000);
    erase_collide("R11 R7 erase collide");
    set_addr(16'h0020);
    do_read("R7 page0 erased");
    set_addr(16'h0202);
    do_read("R7 page1 kept");

    // R7 erase at another divider and counts cleared
    clk_div = 3'd1;
    set_addr(16'h0204);
    do_erase("R7 erase cd1");
    set_data(16'h00FF);
    do_write("R7 write after erase 1");
    do_write("R7 write after erase 2");
    do_write("R6 write after erase 3");
    do_read("R7 readback");
    do_sig("R9 sig after erase");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule